// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is a parameterised FIFO whose writer and reader run on separate clocks. A small dual-port memory holds the words. Binary pointers are kept in each domain, and each pointer also has a registered Gray copy that passes to the other domain through a two-flop synchroniser. Each domain works out the fill level from its own pointer and the synchronised pointer of the other side. From that level the block drives three active-low status outputs: almost-empty, almost-full and half-full. It also drives the plain empty and full indicators.

Two build-time choices shape how the block behaves. The read mode is either standard or first-word-fall-through. In standard mode, each word needs a read request before it appears on the output. In first-word-fall-through mode, the head word is moved into an output register without a request, and the empty output then reports that no valid word is present. That output register adds one word of capacity, so every threshold stated in terms of words held moves up by one. Each programmable flag can be built synchronous, in which case it is updated only in its own domain. It can instead be built asynchronous: it is then asserted by an edge of one clock and released by an edge of the other. Half-full always behaves this way. It is asserted from the write side and released from the read side.

The empty offset n and the full offset m sit in registers that reset loads from parameters. Both defaults are 7 words. In the requirements below, D is the memory depth (16 by default) and "words held" counts the word in the output register when one is there.

Top module: `fifo_flag_gen`

## Requirements
- R1: While reset is active and right after it is released, pae_n_o is 0, paf_n_o is 1, hf_n_o is 1, empty_o is 1 and full_o is 0.
- R2: In standard read mode, once the pointers have settled, pae_n_o is 0 exactly when the FIFO holds n words or fewer.
- R3: In fall-through mode, once settled, pae_n_o is 0 exactly when the FIFO holds n+1 words or fewer.
- R4: Once settled, paf_n_o is 0 exactly when the FIFO holds at least D-m words in standard mode, or at least D+1-m words in fall-through mode.
- R5: In standard mode, hf_n_o is 0 exactly when more than D/2 words are held, so it first goes low after D/2+1 writes with no reads.
- R6: In fall-through mode, hf_n_o is 0 exactly when at least D/2+2 words are held, so it first goes low after D/2+2 writes with no reads.
- R7: empty_o is 1 exactly when no word can be read. full_o is 1 when D words are held in standard mode, or D+1 words in fall-through mode.
- R8: Words leave in the order they were written. In standard mode, the word appears on rdata_o on the read-clock edge that accepts rd_en_i. In fall-through mode, the head word is on rdata_o with no request and stays there until it is read.
- R9: A write while full_o is 1 and a read while nothing is stored are ignored: neither pointer moves, no word is lost, and the standard-mode output keeps its last value.
- R10: An asynchronous programmable flag releases within two edges of its releasing clock. Almost-empty releases on the write clock after the write that takes the level above its threshold. Almost-full releases on the read clock after the read that takes the level below its threshold.
- R11: A synchronous flag changes only through its own domain. After a write crosses the almost-empty threshold, a synchronous almost-empty stays low for the two synchroniser edges and releases on a later read-clock edge.
- R12: hf_n_o goes low within two write-clock edges of the write that takes the level past half, and returns high within two read-clock edges of the read that brings it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| wr_en_i | input | 1 | Write request |
| wdata_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read request |
| rdata_o | output | DATA_W | Read data |
| empty_o | output | 1 | No readable word (fall-through: output not valid) |
| full_o | output | 1 | No room for a write |
| pae_n_o | output | 1 | Almost-empty, active low |
| paf_n_o | output | 1 | Almost-full, active low |
| hf_n_o | output | 1 | Half-full, active low |

## Verification
The assertions check every cycle that a full FIFO never advances the write pointer and an empty memory never advances the read pointer. They also check that the write pointer steps by at most one, that the output data is held while no read is accepted, and that a synchronous almost-empty flag is low after any cycle in which the memory is empty. The exact thresholds depend on how many words are held, and they shift by one in fall-through mode. The bench's scenarios show these thresholds by walking the fill level across each boundary in both read modes. The scenarios also show the one-word extra capacity in fall-through mode and the edge timing that separates asynchronous flags from synchronous ones. Both clocks run from one source in the bench, so the edge counts of R10 to R12 are deterministic there.

// File: rtl/fifo_flag_pkg.sv
`timescale 1ns/1ps
package fifo_flag_pkg;
  typedef enum logic {RD_STD = 1'b0, RD_FWFT = 1'b1} rd_mode_e;
  typedef enum logic {FLAG_SYNC = 1'b0, FLAG_ASYNC = 1'b1} flag_mode_e;
endpackage

// File: rtl/gray_ptr.sv
`timescale 1ns/1ps
// Binary pointer with a registered Gray copy for crossing domains.
module gray_ptr #(
  parameter int unsigned PW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [PW-1:0] bin_o,
  output logic [PW-1:0] gray_o
);
  logic [PW-1:0] bin_q, gray_q, bin_nx;

  assign bin_nx = bin_q + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (inc_i) begin
      bin_q  <= bin_nx;
      gray_q <= bin_nx ^ (bin_nx >> 1);
    end
  end

  assign bin_o  = bin_q;
  assign gray_o = gray_q;
endmodule

// File: rtl/ptr_sync.sv
`timescale 1ns/1ps
module ptr_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/xdom_flag.sv
`timescale 1ns/1ps
// Flag set by one clock and cleared by another: on = set_tog ^ clr_tog.
// Each side sees the other's toggle through two flops before acting.
module xdom_flag #(
  parameter bit INIT_ON = 1'b0
) (
  input  logic set_clk_i,
  input  logic clr_clk_i,
  input  logic rst_ni,
  input  logic set_cond_i,
  input  logic clr_cond_i,
  output logic on_o
);
  logic       set_tog_q, clr_tog_q;
  logic [1:0] clr_seen_q, set_seen_q;
  logic       on_set_view, on_clr_view;

  assign on_set_view = set_tog_q ^ clr_seen_q[1];
  assign on_clr_view = set_seen_q[1] ^ clr_tog_q;

  always_ff @(posedge set_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_tog_q  <= INIT_ON;
      clr_seen_q <= '0;
    end else begin
      clr_seen_q <= {clr_seen_q[0], clr_tog_q};
      if (set_cond_i && !on_set_view) set_tog_q <= ~set_tog_q;
    end
  end

  always_ff @(posedge clr_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_tog_q  <= 1'b0;
      set_seen_q <= {2{INIT_ON}};
    end else begin
      set_seen_q <= {set_seen_q[0], set_tog_q};
      if (clr_cond_i && on_clr_view) clr_tog_q <= ~clr_tog_q;
    end
  end

  assign on_o = set_tog_q ^ clr_tog_q;
endmodule

// File: rtl/dp_ram.sv
`timescale 1ns/1ps
module dp_ram #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i) begin
    if (re_i) rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/fifo_flag_gen.sv
`timescale 1ns/1ps
module fifo_flag_gen
  import fifo_flag_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_W     = 4,
  parameter rd_mode_e    RD_MODE    = RD_STD,
  parameter flag_mode_e  AE_MODE    = FLAG_SYNC,
  parameter flag_mode_e  AF_MODE    = FLAG_SYNC,
  parameter int unsigned AE_OFS_DEF = 7,
  parameter int unsigned AF_OFS_DEF = 7
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              pae_n_o,
  output logic              paf_n_o,
  output logic              hf_n_o
);
  localparam int unsigned PW    = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned HALF  = DEPTH / 2;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---- write domain ----
  logic [PW-1:0] wbin, wgray, rq2_gray, rq2_bin, count_w;
  logic          wr_acc;

  // ---- read domain ----
  logic [PW-1:0] rbin, rgray, wq2_gray, wq2_bin, count_r;
  logic          mem_empty, fetch;

  // offsets, loaded at reset
  logic [PW-1:0] ae_ofs_q, af_ofs_q, af_lvl;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) ae_ofs_q <= PW'(AE_OFS_DEF);
    else         ae_ofs_q <= ae_ofs_q;
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) af_ofs_q <= PW'(AF_OFS_DEF);
    else         af_ofs_q <= af_ofs_q;
  end

  assign af_lvl = PW'(DEPTH) - af_ofs_q;

  assign count_w = wbin - rq2_bin;
  assign full_o  = (count_w == PW'(DEPTH));
  assign wr_acc  = wr_en_i && !full_o;

  gray_ptr #(.PW(PW)) u_wptr (
    .clk_i (wclk_i), .rst_ni(rst_ni), .inc_i(wr_acc),
    .bin_o (wbin),   .gray_o(wgray)
  );

  ptr_sync #(.W(PW), .STAGES(2)) u_rsync (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rq2_gray)
  );
  assign rq2_bin = g2b(rq2_gray);

  ptr_sync #(.W(PW), .STAGES(2)) u_wsync (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wq2_gray)
  );
  assign wq2_bin   = g2b(wq2_gray);
  assign count_r   = wq2_bin - rbin;
  assign mem_empty = (count_r == '0);

  gray_ptr #(.PW(PW)) u_rptr (
    .clk_i (rclk_i), .rst_ni(rst_ni), .inc_i(fetch),
    .bin_o (rbin),   .gray_o(rgray)
  );

  dp_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .wclk_i (wclk_i), .we_i(wr_acc), .waddr_i(wbin[ADDR_W-1:0]), .wdata_i(wdata_i),
    .rclk_i (rclk_i), .re_i(fetch),  .raddr_i(rbin[ADDR_W-1:0]), .rdata_o(rdata_o)
  );

  // ---- read mode ----
  generate
    if (RD_MODE == RD_FWFT) begin : g_fwft
      logic ovalid_q;
      assign fetch = !mem_empty && (!ovalid_q || rd_en_i);
      always_ff @(posedge rclk_i or negedge rst_ni) begin
        if (!rst_ni)      ovalid_q <= 1'b0;
        else if (fetch)   ovalid_q <= 1'b1;
        else if (rd_en_i) ovalid_q <= 1'b0;
      end
      assign empty_o = !ovalid_q;
    end else begin : g_std
      assign fetch   = rd_en_i && !mem_empty;
      assign empty_o = mem_empty;
    end
  endgenerate

  // ---- flags (pointer-difference thresholds; the fall-through register adds the +1) ----
  logic ae_on, af_on, hf_on;

  generate
    if (AE_MODE == FLAG_ASYNC) begin : g_ae_async
      xdom_flag #(.INIT_ON(1'b1)) u_ae (
        .set_clk_i (rclk_i), .clr_clk_i(wclk_i), .rst_ni(rst_ni),
        .set_cond_i(count_r <= ae_ofs_q),
        .clr_cond_i(count_w >  ae_ofs_q),
        .on_o      (ae_on)
      );
    end else begin : g_ae_sync
      logic ae_q;
      always_ff @(posedge rclk_i or negedge rst_ni) begin
        if (!rst_ni) ae_q <= 1'b1;
        else         ae_q <= (count_r <= ae_ofs_q);
      end
      assign ae_on = ae_q;
    end

    if (AF_MODE == FLAG_ASYNC) begin : g_af_async
      xdom_flag #(.INIT_ON(1'b0)) u_af (
        .set_clk_i (wclk_i), .clr_clk_i(rclk_i), .rst_ni(rst_ni),
        .set_cond_i(count_w >= af_lvl),
        .clr_cond_i(count_r <  af_lvl),
        .on_o      (af_on)
      );
    end else begin : g_af_sync
      logic af_q;
      always_ff @(posedge wclk_i or negedge rst_ni) begin
        if (!rst_ni) af_q <= 1'b0;
        else         af_q <= (count_w >= af_lvl);
      end
      assign af_on = af_q;
    end
  endgenerate

  xdom_flag #(.INIT_ON(1'b0)) u_hf (
    .set_clk_i (wclk_i), .clr_clk_i(rclk_i), .rst_ni(rst_ni),
    .set_cond_i(count_w >  PW'(HALF)),
    .clr_cond_i(count_r <= PW'(HALF)),
    .on_o      (hf_on)
  );

  assign pae_n_o = !ae_on;
  assign paf_n_o = !af_on;
  assign hf_n_o  = !hf_on;
endmodule

// File: rtl/fifo_flag_chk.sv
`timescale 1ns/1ps
module fifo_flag_chk
  import fifo_flag_pkg::*;
#(
  parameter int unsigned PW      = 5,
  parameter int unsigned DW      = 8,
  parameter rd_mode_e    RD_MODE = RD_STD,
  parameter flag_mode_e  AE_MODE = FLAG_SYNC
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          rd_en_i,
  input logic          full_o,
  input logic          empty_o,
  input logic          pae_n_o,
  input logic          mem_empty,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin,
  input logic [DW-1:0] rdata_o
);
  // R9: full blocks the write pointer
  a_r9_wptr_hold_full: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o |=> $stable(wbin));

  // R9: empty memory blocks the read pointer
  a_r9_rptr_hold_empty: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    mem_empty |=> $stable(rbin));

  // R8: one word per write edge at most
  a_r8_wptr_single_step: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    1'b1 |=> (wbin == $past(wbin)) || (wbin == $past(wbin) + PW'(1)));

  generate
    if (RD_MODE == RD_FWFT) begin : g_fwft
      // R8: head word stays valid and unchanged until read
      a_r8_head_held: assert property (@(posedge rclk_i) disable iff (!rst_ni)
        (!empty_o && !rd_en_i) |=> ($stable(rdata_o) && !empty_o));
    end else begin : g_std
      // R8: output changes only on an accepted read
      a_r8_data_held: assert property (@(posedge rclk_i) disable iff (!rst_ni)
        !(rd_en_i && !empty_o) |=> $stable(rdata_o));
    end

    if (AE_MODE == FLAG_SYNC) begin : g_ae_sync
      // R2: an empty memory forces the synchronous almost-empty flag low
      a_r2_pae_on_empty: assert property (@(posedge rclk_i) disable iff (!rst_ni)
        mem_empty |=> !pae_n_o);
    end
  endgenerate
endmodule

bind fifo_flag_gen fifo_flag_chk #(
  .PW(PW), .DW(DATA_W), .RD_MODE(RD_MODE), .AE_MODE(AE_MODE)
) u_chk (
  .wclk_i   (wclk_i),
  .rclk_i   (rclk_i),
  .rst_ni   (rst_ni),
  .rd_en_i  (rd_en_i),
  .full_o   (full_o),
  .empty_o  (empty_o),
  .pae_n_o  (pae_n_o),
  .mem_empty(mem_empty),
  .wbin     (wbin),
  .rbin     (rbin),
  .rdata_o  (rdata_o)
);

// File: tb/sim_fifo_flag_gen.sv
`timescale 1ns/1ps
module sim_fifo_flag_gen;
  import fifo_flag_pkg::*;

  localparam int unsigned DW   = 8;
  localparam int unsigned D    = 16;
  localparam int unsigned OFS  = 7;
  localparam int unsigned CAP0 = D;
  localparam int unsigned CAP1 = D + 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd0, rd1;
  logic          e0, f0, ae0, af0, hf0;
  logic          e1, f1, ae1, af1, hf1;

  // u0: standard read, synchronous flags
  fifo_flag_gen #(.DATA_W(DW), .ADDR_W(4), .RD_MODE(RD_STD),
                  .AE_MODE(FLAG_SYNC), .AF_MODE(FLAG_SYNC)) u0 (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en),
    .rdata_o(rd0), .empty_o(e0), .full_o(f0),
    .pae_n_o(ae0), .paf_n_o(af0), .hf_n_o(hf0)
  );

  // u1: fall-through read, asynchronous flags
  fifo_flag_gen #(.DATA_W(DW), .ADDR_W(4), .RD_MODE(RD_FWFT),
                  .AE_MODE(FLAG_ASYNC), .AF_MODE(FLAG_ASYNC)) u1 (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en),
    .rdata_o(rd1), .empty_o(e1), .full_o(f1),
    .pae_n_o(ae1), .paf_n_o(af1), .hf_n_o(hf1)
  );

  int checks = 0, errs = 0;
  int q0[$], q1[$];
  int seq = 1;
  int last0 = 0;
  bit have_last0 = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  task automatic push_models();
    if (q0.size() < CAP0) q0.push_back(seq);
    if (q1.size() < CAP1) q1.push_back(seq);
    seq++;
  endtask

  task automatic do_write(input int n);
    @(negedge clk);
    wr_en = 1'b1; wdata = DW'(seq);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      push_models();
      wdata = DW'(seq);
      if (i == n - 1) wr_en = 1'b0;
    end
  endtask

  task automatic do_read(input int n);
    @(negedge clk);
    rd_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (q1.size() > 0) chk("R8 fwft head", int'(rd1), q1[0]);
      @(posedge clk); @(negedge clk);
      if (q0.size() > 0) begin
        last0 = q0.pop_front(); have_last0 = 1'b1;
        chk("R8 std read data", int'(rd0), last0);
      end else if (have_last0) begin
        chk("R9 std read on empty keeps data", int'(rd0), last0);
      end
      if (q1.size() > 0) void'(q1.pop_front());
      if (i == n - 1) rd_en = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (8) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_state();
    int t0 = q0.size();
    int t1 = q1.size();
    chk("R2 std pae",  int'(ae0), int'(!(t0 <= OFS)));
    chk("R3 fwft pae", int'(ae1), int'(!(t1 <= OFS + 1)));
    chk("R4 std paf",  int'(af0), int'(!(t0 >= D - OFS)));
    chk("R4 fwft paf", int'(af1), int'(!(t1 >= D + 1 - OFS)));
    chk("R5 std hf",   int'(hf0), int'(!(t0 > D / 2)));
    chk("R6 fwft hf",  int'(hf1), int'(!(t1 >= D / 2 + 2)));
    chk("R7 std empty",  int'(e0), int'(t0 == 0));
    chk("R7 fwft empty", int'(e1), int'(t1 == 0));
    chk("R7 std full",   int'(f0), int'(t0 == CAP0));
    chk("R7 fwft full",  int'(f1), int'(t1 == CAP1));
    if (t1 > 0) chk("R8 fwft falls through", int'(rd1), q1[0]);
  endtask

  task automatic check_reset_state(input string tag);
    chk({"R1 pae0 ", tag}, int'(ae0), 0);
    chk({"R1 pae1 ", tag}, int'(ae1), 0);
    chk({"R1 paf0 ", tag}, int'(af0), 1);
    chk({"R1 paf1 ", tag}, int'(af1), 1);
    chk({"R1 hf0 ", tag},  int'(hf0), 1);
    chk({"R1 hf1 ", tag},  int'(hf1), 1);
    chk({"R1 empty0 ", tag}, int'(e0), 1);
    chk({"R1 empty1 ", tag}, int'(e1), 1);
    chk({"R1 full0 ", tag},  int'(f0), 0);
    chk({"R1 full1 ", tag},  int'(f1), 0);
  endtask

  // write or read once, then sample 1.5 cycles after the accepting edge
  task automatic write_peek();
    @(negedge clk); wr_en = 1'b1; wdata = DW'(seq);
    @(posedge clk); @(negedge clk); wr_en = 1'b0; push_models();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic read_peek();
    @(negedge clk); rd_en = 1'b1;
    @(posedge clk); @(negedge clk); rd_en = 1'b0;
    if (q0.size() > 0) begin last0 = q0.pop_front(); have_last0 = 1'b1; end
    if (q1.size() > 0) void'(q1.pop_front());
    @(posedge clk); @(negedge clk);
  endtask

  localparam int N_STEPS = 11;
  localparam int STEP_WR [N_STEPS] = '{3, 4, 1, 1, 1, 6, 2, 0, 0, 0, 0};
  localparam int STEP_RD [N_STEPS] = '{0, 0, 0, 0, 0, 0, 0, 1, 8, 7, 3};

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state("during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("after release");

    // table walk across every threshold, both read modes
    for (int s = 0; s < N_STEPS; s++) begin
      if (STEP_WR[s] > 0) do_write(STEP_WR[s]);
      if (STEP_RD[s] > 0) do_read(STEP_RD[s]);
      settle();
      check_state();
    end

    // R9: u0 kept 16 and u1 17; the rest were dropped, both drained
    chk("R9 models drained", q0.size() + q1.size(), 0);

    // flag edge timing
    do_write(7); settle(); check_state();
    write_peek();                          // level 8
    chk("R11 sync pae still low", int'(ae0), 0);
    chk("R3 fwft pae at 8", int'(ae1), 0);
    settle();
    chk("R11 sync pae released later", int'(ae0), 1);
    write_peek();                          // level 9
    chk("R10 async pae released on write edge", int'(ae1), 1);
    chk("R12 hf set from write edge", int'(hf0), 0);
    settle(); check_state();
    write_peek();                          // level 10
    chk("R12 fwft hf set from write edge", int'(hf1), 0);
    settle(); check_state();
    read_peek();                           // level 9
    chk("R10 async paf released on read edge", int'(af1), 1);
    chk("R12 fwft hf released on read edge", int'(hf1), 1);
    settle(); check_state();

    // reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check_reset_state("mid-run");
    q0.delete(); q1.delete(); have_last0 = 1'b0;
    rst_n = 1'b1;
    settle(); check_state();

    summary();
  end
endmodule